// File: doc/BRIEF.md
# PLL Bring-Up and Lock Sequencer

This block is a small sequencer that moves the system clock onto a PLL in a safe order, and takes it off again in a safe order. A start request carries three divider values: input, feedback and output. The block range-checks all three in hardware. If any value is out of range, the request is refused and an error flag is set. If all three are legal, the block runs a fixed sequence:

1. It points the frequency-reference source multiplexer at the 4 MHz reference.
2. It switches the ring oscillator off.
3. It loads the encoded divider fields and enables the PLL.
4. It waits a lock interval counted on the 4 MHz reference clock.
5. Only after that wait does it move the system clock onto the PLL output.

A stop request while the system runs from the PLL works in the reverse order. The system clock goes back to the reference path first, and the PLL enable drops one cycle later. The analog loop itself lies outside the block. The block drives only the enables, the multiplexer selects and the divider fields.

The block runs on the reference clock. The lock interval is 2000 of those cycles, which is 500 us at 4 MHz. While a sequence is in flight, a busy flag is raised, and further start and stop requests are ignored.

Top module: `pll_lock_seq`

## Requirements
- R1: After reset the outputs take these values. The source select is 1, which means ring oscillator (code 0 = 4 MHz reference, 1 = ring oscillator). The ring oscillator enable is 1. The PLL enable, the system-on-PLL select, the locked flag, busy and error are all 0. All three divider code outputs are 0.
- R2: A start sampled in idle is refused when any divider is out of range. The legal ranges are: input 2..33, feedback 2..513, output 1..16. On a refused start, the error flag is 1 on the next cycle, busy stays 0, the PLL stays disabled, and the divider code outputs keep their previous values.
- R3: An accepted start sets the source select to 0 one cycle later. It clears the ring oscillator enable one cycle after that. It raises the PLL enable one cycle after that.
- R4: The divider codes are loaded in the same cycle that the PLL enable rises. Each code is the value minus the range minimum: input code = value−2 (5 bits), feedback code = value−2 (9 bits), output code = value−1 (4 bits).
- R5: The locked flag rises exactly LOCK_CYCLES (default 2000) cycles after the PLL enable rises.
- R6: The system-on-PLL select rises one cycle after the locked flag. It is never 1 unless both the PLL enable and the locked flag are 1.
- R7: Busy is 1 from the cycle after an accepted start until the system-on-PLL select rises. A start request is ignored while busy and while running on the PLL. Its divider values do not reach the code outputs.
- R8: A stop while running on the PLL clears the system-on-PLL select on the next cycle, with busy 1. The cycle after that, it clears the PLL enable, the locked flag and busy.
- R9: A stop is ignored in idle and while a start sequence is in flight.
- R10: An accepted start clears a previously set error flag on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 4 MHz reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to bring the PLL into use |
| stop_i | input | 1 | Request to leave the PLL and disable it |
| in_div_i | input | 6 | Requested input divider value |
| fb_div_i | input | 10 | Requested feedback divider value |
| out_div_i | input | 5 | Requested output divider value |
| src_sel_o | output | 2 | Reference source select (0 = 4 MHz reference, 1 = ring oscillator) |
| rosc_en_o | output | 1 | Ring oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| in_code_o | output | 5 | Encoded input divider field |
| fb_code_o | output | 9 | Encoded feedback divider field |
| out_code_o | output | 4 | Encoded output divider field |
| sys_on_pll_o | output | 1 | System clock select, 1 = PLL output |
| locked_o | output | 1 | Lock interval has elapsed |
| busy_o | output | 1 | Start or stop sequence in flight |
| err_o | output | 1 | Last start request had an illegal divider |

## Verification
The hardest situation to reach from the ports is a request arriving in the middle of the 2000-cycle lock wait. That covers a fresh start carrying different dividers, and a stop. Neither request must disturb the count, the loaded fields or the final switch-over. The stimulus waits for the PLL enable to rise. It then injects both requests at fixed offsets inside the wait. After the switch-over, it checks that the lock count is still exact and the divider codes are still the original ones. Boundary divider values are driven both inside and just outside each range, alongside random values drawn partly outside the ranges.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REF,
    ST_ROSC,
    ST_LOAD,
    ST_WAIT,
    ST_SWITCH,
    ST_RUN,
    ST_DROP
  } seq_state_t;

  localparam logic [1:0] SRC_REF4M = 2'd0;
  localparam logic [1:0] SRC_RING  = 2'd1;

endpackage

// File: rtl/pll_div_field.sv
module pll_div_field #(
  parameter int W  = 6,
  parameter int LO = 2,
  parameter int HI = 33,
  parameter int CW = 5
) (
  input  logic [W-1:0]  raw_i,
  output logic          ok_o,
  output logic [CW-1:0] code_o
);

  function automatic logic is_legal(logic [W-1:0] v);
    return (v >= W'(LO)) && (v <= W'(HI));
  endfunction

  function automatic logic [CW-1:0] to_code(logic [W-1:0] v);
    logic [W-1:0] d;
    d = v - W'(LO);
    return d[CW-1:0];
  endfunction

  always_comb begin
    ok_o   = is_legal(raw_i);
    code_o = ok_o ? to_code(raw_i) : '0;
  end

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int CYCLES = 2000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == CW'(CYCLES - 1));

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter logic [1:0] RST_SRC = SRC_RING
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       cfg_ok_i,
  input  logic       lock_done_i,
  output logic [1:0] src_sel_o,
  output logic       rosc_en_o,
  output logic       pll_en_o,
  output logic       sys_on_pll_o,
  output logic       locked_o,
  output logic       busy_o,
  output logic       accept_o,
  output logic       reject_o,
  output logic       load_o,
  output logic       tmr_clear_o,
  output logic       tmr_run_o
);

  seq_state_t state_q;

  always_comb begin
    accept_o    = (state_q == ST_IDLE) && start_i && cfg_ok_i;
    reject_o    = (state_q == ST_IDLE) && start_i && !cfg_ok_i;
    load_o      = (state_q == ST_LOAD);
    tmr_clear_o = (state_q == ST_LOAD);
    tmr_run_o   = (state_q == ST_WAIT);
    busy_o      = !((state_q == ST_IDLE) || (state_q == ST_RUN));
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      src_sel_o    <= RST_SRC;
      rosc_en_o    <= 1'b1;
      pll_en_o     <= 1'b0;
      sys_on_pll_o <= 1'b0;
      locked_o     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE:   if (accept_o) state_q <= ST_REF;
        ST_REF: begin
          src_sel_o <= SRC_REF4M;
          state_q   <= ST_ROSC;
        end
        ST_ROSC: begin
          rosc_en_o <= 1'b0;
          state_q   <= ST_LOAD;
        end
        ST_LOAD: begin
          pll_en_o <= 1'b1;
          state_q  <= ST_WAIT;
        end
        ST_WAIT: if (lock_done_i) begin
          locked_o <= 1'b1;
          state_q  <= ST_SWITCH;
        end
        ST_SWITCH: begin
          sys_on_pll_o <= 1'b1;
          state_q      <= ST_RUN;
        end
        ST_RUN: if (stop_i) begin
          sys_on_pll_o <= 1'b0;
          state_q      <= ST_DROP;
        end
        ST_DROP: begin
          pll_en_o <= 1'b0;
          locked_o <= 1'b0;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_lock_seq.sv
module pll_lock_seq
  import pll_seq_pkg::*;
#(
  parameter int         IN_MIN      = 2,
  parameter int         IN_MAX      = 33,
  parameter int         FB_MIN      = 2,
  parameter int         FB_MAX      = 513,
  parameter int         OUT_MIN     = 1,
  parameter int         OUT_MAX     = 16,
  parameter int         LOCK_CYCLES = 2000,
  parameter logic [1:0] RST_SRC     = SRC_RING,
  localparam int IN_W   = $clog2(IN_MAX + 1),
  localparam int FB_W   = $clog2(FB_MAX + 1),
  localparam int OUT_W  = $clog2(OUT_MAX + 1),
  localparam int IN_CW  = $clog2(IN_MAX - IN_MIN + 1),
  localparam int FB_CW  = $clog2(FB_MAX - FB_MIN + 1),
  localparam int OUT_CW = $clog2(OUT_MAX - OUT_MIN + 1)
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [IN_W-1:0]   in_div_i,
  input  logic [FB_W-1:0]   fb_div_i,
  input  logic [OUT_W-1:0]  out_div_i,
  output logic [1:0]        src_sel_o,
  output logic              rosc_en_o,
  output logic              pll_en_o,
  output logic [IN_CW-1:0]  in_code_o,
  output logic [FB_CW-1:0]  fb_code_o,
  output logic [OUT_CW-1:0] out_code_o,
  output logic              sys_on_pll_o,
  output logic              locked_o,
  output logic              busy_o,
  output logic              err_o
);

  logic              in_ok, fb_ok, out_ok, cfg_ok;
  logic [IN_CW-1:0]  in_code_w;
  logic [FB_CW-1:0]  fb_code_w;
  logic [OUT_CW-1:0] out_code_w;
  logic              accept_w, reject_w, load_w;
  logic              tmr_clear_w, tmr_run_w, lock_done_w;

  logic [IN_CW-1:0]  in_cap_q;
  logic [FB_CW-1:0]  fb_cap_q;
  logic [OUT_CW-1:0] out_cap_q;

  pll_div_field #(.W(IN_W), .LO(IN_MIN), .HI(IN_MAX), .CW(IN_CW)) u_in_chk (
    .raw_i(in_div_i), .ok_o(in_ok), .code_o(in_code_w)
  );
  pll_div_field #(.W(FB_W), .LO(FB_MIN), .HI(FB_MAX), .CW(FB_CW)) u_fb_chk (
    .raw_i(fb_div_i), .ok_o(fb_ok), .code_o(fb_code_w)
  );
  pll_div_field #(.W(OUT_W), .LO(OUT_MIN), .HI(OUT_MAX), .CW(OUT_CW)) u_out_chk (
    .raw_i(out_div_i), .ok_o(out_ok), .code_o(out_code_w)
  );

  assign cfg_ok = in_ok && fb_ok && out_ok;

  pll_lock_timer #(.CYCLES(LOCK_CYCLES)) u_timer (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .clear_i (tmr_clear_w),
    .run_i   (tmr_run_w),
    .done_o  (lock_done_w)
  );

  pll_seq_fsm #(.RST_SRC(RST_SRC)) u_fsm (
    .clk_ref      (clk_ref),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .cfg_ok_i     (cfg_ok),
    .lock_done_i  (lock_done_w),
    .src_sel_o    (src_sel_o),
    .rosc_en_o    (rosc_en_o),
    .pll_en_o     (pll_en_o),
    .sys_on_pll_o (sys_on_pll_o),
    .locked_o     (locked_o),
    .busy_o       (busy_o),
    .accept_o     (accept_w),
    .reject_o     (reject_w),
    .load_o       (load_w),
    .tmr_clear_o  (tmr_clear_w),
    .tmr_run_o    (tmr_run_w)
  );

  // Requested codes are held from acceptance and published at load time
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      in_cap_q   <= '0;
      fb_cap_q   <= '0;
      out_cap_q  <= '0;
      in_code_o  <= '0;
      fb_code_o  <= '0;
      out_code_o <= '0;
      err_o      <= 1'b0;
    end else begin
      if (accept_w) begin
        in_cap_q  <= in_code_w;
        fb_cap_q  <= fb_code_w;
        out_cap_q <= out_code_w;
        err_o     <= 1'b0;
      end else if (reject_w) begin
        err_o <= 1'b1;
      end
      if (load_w) begin
        in_code_o  <= in_cap_q;
        fb_code_o  <= fb_cap_q;
        out_code_o <= out_cap_q;
      end
    end
  end

endmodule

// File: rtl/pll_lock_seq_chk.sv
module pll_lock_seq_chk #(
  parameter int LOCK_CYCLES = 2000
) (
  input logic       clk_ref,
  input logic       rst_n,
  input logic       start_i,
  input logic       stop_i,
  input logic [1:0] src_sel_o,
  input logic       rosc_en_o,
  input logic       pll_en_o,
  input logic       sys_on_pll_o,
  input logic       locked_o,
  input logic       busy_o,
  input logic       err_o,
  input logic       accept_w,
  input logic       reject_w
);

  int win_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)                     win_q <= 0;
    else if (!pll_en_o)             win_q <= 0;
    else if (pll_en_o && !locked_o) win_q <= win_q + 1;
  end

  assert_reject_err_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    reject_w |=> (err_o && !busy_o && !pll_en_o));

  assert_ref_first_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(pll_en_o) |-> (src_sel_o == 2'd0 && !rosc_en_o));

  assert_lock_window_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(locked_o) |-> (win_q == LOCK_CYCLES));

  assert_sys_needs_lock_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    sys_on_pll_o |-> (pll_en_o && locked_o));

  assert_switch_after_lock_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(sys_on_pll_o) |-> $past(locked_o));

  assert_accept_idle_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    accept_w |-> (!busy_o && !sys_on_pll_o && !pll_en_o));

  assert_drop_order_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(pll_en_o) |-> (!sys_on_pll_o && !$past(sys_on_pll_o)));

  assert_stop_idle_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (stop_i && !start_i && !busy_o && !sys_on_pll_o && !pll_en_o) |=> !pll_en_o);

endmodule

bind pll_lock_seq pll_lock_seq_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .clk_ref      (clk_ref),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .src_sel_o    (src_sel_o),
  .rosc_en_o    (rosc_en_o),
  .pll_en_o     (pll_en_o),
  .sys_on_pll_o (sys_on_pll_o),
  .locked_o     (locked_o),
  .busy_o       (busy_o),
  .err_o        (err_o),
  .accept_w     (accept_w),
  .reject_w     (reject_w)
);

// File: tb/pll_lock_seq_bench.sv
`timescale 1ns/1ps
module pll_lock_seq_bench;

  localparam int LOCK = 2000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, stop;
  logic [5:0] in_div;
  logic [9:0] fb_div;
  logic [4:0] out_div;
  logic [1:0] src_sel;
  logic       rosc_en, pll_en, sys_on_pll, locked, busy, err;
  logic [4:0] in_code;
  logic [8:0] fb_code;
  logic [3:0] out_code;

  int checks = 0;
  int fails  = 0;
  int prev_in = 0, prev_fb = 0, prev_out = 0;

  always #4 clk = ~clk;

  pll_lock_seq u_pll_lock_seq (
    .clk_ref(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop),
    .in_div_i(in_div), .fb_div_i(fb_div), .out_div_i(out_div),
    .src_sel_o(src_sel), .rosc_en_o(rosc_en), .pll_en_o(pll_en),
    .in_code_o(in_code), .fb_code_o(fb_code), .out_code_o(out_code),
    .sys_on_pll_o(sys_on_pll), .locked_o(locked), .busy_o(busy), .err_o(err)
  );

  function automatic bit legal(int i, int f, int o);
    return (i inside {[2:33]}) && (f inside {[2:513]}) && (o inside {[1:16]});
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_codes(input string req, input int ei, input int ef, input int eo);
    chk(req, "in_code", int'(in_code), ei);
    chk(req, "fb_code", int'(fb_code), ef);
    chk(req, "out_code", int'(out_code), eo);
  endtask

  task automatic run_start(input int i, input int f, input int o);
    int n;
    @(negedge clk);
    in_div = 6'(i); fb_div = 10'(f); out_div = 5'(o); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!legal(i, f, o)) begin
      chk("R2", "err", int'(err), 1);
      chk("R2", "busy", int'(busy), 0);
      chk("R2", "pll_en", int'(pll_en), 0);
      chk_codes("R2", prev_in, prev_fb, prev_out);
      repeat (3) @(negedge clk);
      chk("R2", "pll_en later", int'(pll_en), 0);
      return;
    end
    chk("R7", "busy after accept", int'(busy), 1);
    chk("R10", "err cleared", int'(err), 0);
    @(negedge clk);
    chk("R3", "src ref", int'(src_sel), 0);
    @(negedge clk);
    chk("R3", "ring off", int'(rosc_en), 0);
    chk("R3", "pll not yet", int'(pll_en), 0);
    @(negedge clk);
    chk("R3", "pll on", int'(pll_en), 1);
    chk_codes("R4", i - 2, f - 2, o - 1);
    n = 0;
    while (!locked && n < LOCK + 50) begin
      n++;
      if (n == 5) begin
        start = 1'b1; in_div = 6'd3; fb_div = 10'd7; out_div = 5'd2;
      end
      if (n == 6) start = 1'b0;
      if (n == 9) stop = 1'b1;
      if (n == 10) stop = 1'b0;
      if (n == 20) chk("R6", "sys before lock", int'(sys_on_pll), 0);
      @(negedge clk);
    end
    chk("R5", "lock cycles", n, LOCK);
    chk("R6", "sys same cycle as lock", int'(sys_on_pll), 0);
    @(negedge clk);
    chk("R6", "sys on pll", int'(sys_on_pll), 1);
    chk("R7", "busy cleared", int'(busy), 0);
    chk("R9", "pll kept after stop in flight", int'(pll_en), 1);
    chk_codes("R7", i - 2, f - 2, o - 1);
    prev_in = i - 2; prev_fb = f - 2; prev_out = o - 1;
  endtask

  task automatic stop_pll();
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8", "sys dropped first", int'(sys_on_pll), 0);
    chk("R8", "pll still on", int'(pll_en), 1);
    chk("R8", "busy in drop", int'(busy), 1);
    @(negedge clk);
    chk("R8", "pll off", int'(pll_en), 0);
    chk("R8", "locked off", int'(locked), 0);
    chk("R8", "busy off", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; start = 1'b0; stop = 1'b0;
    in_div = '0; fb_div = '0; out_div = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "src", int'(src_sel), 1);
    chk("R1", "rosc_en", int'(rosc_en), 1);
    chk("R1", "pll_en", int'(pll_en), 0);
    chk("R1", "sys_on_pll", int'(sys_on_pll), 0);
    chk("R1", "locked", int'(locked), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "err", int'(err), 0);
    chk_codes("R1", 0, 0, 0);

    // R9: stop in idle has no effect
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    @(negedge clk);
    chk("R9", "idle stop pll", int'(pll_en), 0);
    chk("R9", "idle stop busy", int'(busy), 0);
    chk("R9", "idle stop src", int'(src_sel), 1);

    run_start(1, 100, 4);
    run_start(2, 2, 1);
    // R7: start while running on the PLL is ignored
    @(negedge clk);
    start = 1'b1; in_div = 6'd9; fb_div = 10'd9; out_div = 5'd9;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7", "run start sys", int'(sys_on_pll), 1);
    chk("R7", "run start busy", int'(busy), 0);
    chk_codes("R7", 0, 0, 0);
    stop_pll();

    run_start(34, 10, 3);
    run_start(5, 514, 3);
    run_start(5, 50, 0);
    run_start(5, 50, 17);
    run_start(0, 1, 3);
    run_start(33, 513, 16);
    stop_pll();
    run_start(10, 200, 5);
    stop_pll();

    for (int k = 0; k < 12; k++) begin
      int ri, rf, ro;
      ri = int'($urandom_range(0, 40));
      rf = int'($urandom_range(0, 530));
      ro = int'($urandom_range(0, 20));
      run_start(ri, rf, ro);
      if (legal(ri, rf, ro)) stop_pll();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule